// File: doc/BRIEF.md
# Register Bank Slave with Wait-State Acknowledge

This block is a small bank of 32-bit registers that sits behind a simple bus-to-IP interconnect. The interconnect does the address decode. It presents each request as a chip-select vector, a read-not-write flag and two one-hot enable vectors, one for reads and one for writes. Bit i of either enable vector selects register i, so the bank itself does no address comparison.

Every transfer ends with one acknowledge pulse. A programmable count of wait states can delay that pulse. On a write, data is taken on the rising edge at which the write acknowledge is high, and only the byte lanes whose enable bit is set are updated. On a read, data is valid only while the read acknowledge is high, and the read bus is zero at all other times. An error flag can accompany an acknowledge, but it never appears on its own. The error is raised for:
- a write to the read-only last register;
- a request with more than one enable bit set;
- a request whose enable does not match the direction flag.

Top module: `regbank_slave`

## Requirements
- R1: While `rst_n` is low no acknowledge is given. After reset, registers 0 to 2 read as zero and register 3 reads the constant `RO_VALUE` (default 32'h5A17_0003).
- R2: With `wait_states` = N at the start of a request, the acknowledge comes in cycle N counted from the request's first cycle, so N = 0 acknowledges in the same cycle.
- R3: Each acknowledge lasts one cycle. A request that stays asserted is not acknowledged again until its enable has dropped and risen again.
- R4: A clean write updates only the lanes whose `be` bit is set, where `be[j]` guards `wdata[8j+7:8j]`. Lanes are numbered from the MSB side, so lane 0 is bits 31:24 and `be` = 4'b0011 selects lanes 2 and 3 (bits 15:0).
- R5: On a clean read, `rdata` equals the selected register while `rd_ack` is high. `rdata` is zero whenever `rd_ack` is low.
- R6: A write to register 3 is acknowledged with `err` high and leaves every register unchanged.
- R7: A request counts as faulty when either of these holds:
  - the number of bits set across `rd_ce` and `wr_ce` together is not exactly one;
  - the set bit lies in the enable vector that does not match `rnw`.
  A faulty request is acknowledged with `err` high, changes no register, and a faulty read returns zero data.
- R8: `err` is high only in a cycle in which `rd_ack` or `wr_ack` is high.
- R9: If a request drops before its wait states have elapsed, no acknowledge is given and no register changes. A request is present only when some `cs` bit is high and some enable bit is high.
- R10: `rd_ack` fires only for requests with `rnw` = 1 and `wr_ack` only for `rnw` = 0. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Request address; decode is done upstream, so it is not used here |
| cs | input | CSW | Chip-select vector; a request needs at least one bit high |
| rnw | input | 1 | 1 = read, 0 = write |
| wdata | input | DW | Write data |
| be | input | DW/8 | Byte-lane enables; bit j guards bits 8j+7:8j |
| rd_ce | input | NREG | One-hot read enable; bit i selects register i |
| wr_ce | input | NREG | One-hot write enable; bit i selects register i |
| wait_states | input | WAIT_W | Number of wait cycles before the acknowledge |
| rdata | output | DW | Read data; zero unless `rd_ack` is high |
| rd_ack | output | 1 | Single-cycle read acknowledge |
| wr_ack | output | 1 | Single-cycle write acknowledge |
| err | output | 1 | Error qualifier given together with an acknowledge |

## Verification
The bound checker watches, on every cycle, these properties:
- the two acknowledges are never high together;
- `err` never appears without an acknowledge;
- every acknowledge lasts exactly one cycle;
- read data is zero outside `rd_ack`;
- there is no acknowledge without a request;
- an erroring write leaves the register contents untouched.

Only the bench's scenarios can show the rest:
- the exact wait-state latency for each programmed count;
- byte-lane merging;
- the values read back after writes;
- the reset contents;
- that an aborted request writes nothing.

The bench measures these against its own model of the bank.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_DONE = 2'd2
  } hs_state_e;
endpackage

// File: rtl/regbank_hs.sv
// Acknowledge sequencer: counts wait states from the first request cycle,
// issues one pulse, then holds off until the request is withdrawn.
module regbank_hs
  import regbank_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [WAIT_W-1:0] wait_states,
  output logic              ack_now
);
  hs_state_e         state;
  logic [WAIT_W-1:0] cnt;
  logic [WAIT_W-1:0] wait_lat;
  logic              ack_raw;

  always_comb begin
    case (state)
      HS_IDLE: ack_raw = req && (wait_states == '0);
      HS_WAIT: ack_raw = req && (cnt == wait_lat);
      default: ack_raw = 1'b0;
    endcase
  end

  assign ack_now = rst_n && ack_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= HS_IDLE;
      cnt      <= '0;
      wait_lat <= '0;
    end else begin
      case (state)
        HS_IDLE: begin
          if (req) begin
            if (wait_states == '0) begin
              state <= HS_DONE;
            end else begin
              state    <= HS_WAIT;
              cnt      <= WAIT_W'(1);
              wait_lat <= wait_states;
            end
          end
        end
        HS_WAIT: begin
          if (!req)                 state <= HS_IDLE;
          else if (cnt == wait_lat) state <= HS_DONE;
          else                      cnt   <= cnt + WAIT_W'(1);
        end
        HS_DONE: begin
          if (!req) state <= HS_IDLE;
        end
        default: state <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regbank_store.sv
// Register storage with per-byte write enables; one index is a read-only constant.
module regbank_store #(
  parameter int              NREG     = 4,
  parameter int              DW       = 32,
  parameter int              RO_IDX   = NREG - 1,
  parameter logic [DW-1:0]   RO_VALUE = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [NREG-1:0]          wr_sel,
  input  logic [DW/8-1:0]          be,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  regs
);
  localparam int NB = DW / 8;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r == RO_IDX) begin : g_ro
      assign regs[r] = RO_VALUE;
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= '0;
        end else if (wr_en && wr_sel[r]) begin
          for (int b = 0; b < NB; b++) begin
            if (be[b]) q[b*8 +: 8] <= wdata[b*8 +: 8];
          end
        end
      end
      assign regs[r] = q;
    end
  end
endmodule

// File: rtl/regbank_rdsel.sv
// AND-OR read selector, forced to zero when not enabled.
module regbank_rdsel #(
  parameter int NREG = 4,
  parameter int DW   = 32
) (
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic [NREG-1:0]         sel,
  input  logic                    en,
  output logic [DW-1:0]           rdata
);
  logic [DW-1:0] merged;

  always_comb begin
    merged = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel[i]) merged = merged | regs[i];
    end
  end

  assign rdata = en ? merged : '0;
endmodule

// File: rtl/regbank_slave.sv
module regbank_slave #(
  parameter int            AW       = 8,
  parameter int            CSW      = 1,
  parameter int            DW       = 32,
  parameter int            NREG     = 4,
  parameter int            WAIT_W   = 4,
  parameter logic [DW-1:0] RO_VALUE = 'h5A17_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [CSW-1:0]    cs,
  input  logic              rnw,
  input  logic [DW-1:0]     wdata,
  input  logic [DW/8-1:0]   be,
  input  logic [NREG-1:0]   rd_ce,
  input  logic [NREG-1:0]   wr_ce,
  input  logic [WAIT_W-1:0] wait_states,
  output logic [DW-1:0]     rdata,
  output logic              rd_ack,
  output logic              wr_ack,
  output logic              err
);
  localparam int RO_IDX = NREG - 1;

  logic                    req;
  logic                    ack_now;
  logic                    single_hot;
  logic                    dir_ok;
  logic                    fault;
  logic                    wr_en;
  logic [NREG-1:0][DW-1:0] reg_q;
  logic                    unused_addr;

  assign unused_addr = ^addr;

  assign req        = (|cs) && ((|rd_ce) || (|wr_ce));
  assign single_hot = ($countones({rd_ce, wr_ce}) == 1);
  assign dir_ok     = rnw ? (|rd_ce) : (|wr_ce);
  assign fault      = !single_hot || !dir_ok || wr_ce[RO_IDX];

  regbank_hs #(.WAIT_W(WAIT_W)) u_hs (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .wait_states (wait_states),
    .ack_now     (ack_now)
  );

  assign rd_ack = ack_now && rnw;
  assign wr_ack = ack_now && !rnw;
  assign err    = ack_now && fault;
  assign wr_en  = wr_ack && !fault;

  regbank_store #(
    .NREG     (NREG),
    .DW       (DW),
    .RO_IDX   (RO_IDX),
    .RO_VALUE (RO_VALUE)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_ce),
    .be     (be),
    .wdata  (wdata),
    .regs   (reg_q)
  );

  regbank_rdsel #(.NREG(NREG), .DW(DW)) u_rdsel (
    .regs  (reg_q),
    .sel   (rd_ce),
    .en    (rd_ack && !fault),
    .rdata (rdata)
  );
endmodule

// File: rtl/regbank_slave_chk.sv
module regbank_slave_chk #(
  parameter int CSW  = 1,
  parameter int DW   = 32,
  parameter int NREG = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CSW-1:0]          cs,
  input logic [NREG-1:0]         rd_ce,
  input logic [NREG-1:0]         wr_ce,
  input logic [DW-1:0]           rdata,
  input logic                    rd_ack,
  input logic                    wr_ack,
  input logic                    err,
  input logic [NREG-1:0][DW-1:0] regs_q
);
  logic any_ack;
  logic req_seen;
  assign any_ack  = rd_ack || wr_ack;
  assign req_seen = (|cs) && ((|rd_ce) || (|wr_ce));

  p_one_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ack && wr_ack));

  p_err_with_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> any_ack);

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_ack |=> !any_ack);

  p_rdata_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ack |-> (rdata == '0));

  p_no_req_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_seen |-> !any_ack);

  p_err_nochange_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && err) |=> $stable(regs_q));
endmodule

bind regbank_slave regbank_slave_chk #(.CSW(CSW), .DW(DW), .NREG(NREG)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs     (cs),
  .rd_ce  (rd_ce),
  .wr_ce  (wr_ce),
  .rdata  (rdata),
  .rd_ack (rd_ack),
  .wr_ack (wr_ack),
  .err    (err),
  .regs_q (reg_q)
);

// File: tb/regbank_slave_bench.sv
`timescale 1ns/1ps
module regbank_slave_bench;
  localparam logic [31:0] RO_VAL = 32'h5A17_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [0:0]  cs = '0;
  logic        rnw = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [3:0]  rd_ce = '0;
  logic [3:0]  wr_ce = '0;
  logic [3:0]  wait_states = '0;
  logic [31:0] rdata;
  logic        rd_ack;
  logic        wr_ack;
  logic        err;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [4];

  always #4 clk = ~clk;

  regbank_slave u_regbank_slave (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs(cs), .rnw(rnw),
    .wdata(wdata), .be(be), .rd_ce(rd_ce), .wr_ce(wr_ce),
    .wait_states(wait_states), .rdata(rdata), .rd_ack(rd_ack),
    .wr_ack(wr_ack), .err(err)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old,
                                        input logic [31:0] d, input logic [3:0] b);
    logic [31:0] r = old;
    for (int j = 0; j < 4; j++) if (b[j]) r[j*8 +: 8] = d[j*8 +: 8];
    return r;
  endfunction

  function automatic int hot_idx(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic bit is_fault(input logic r, input logic [3:0] rc,
                                  input logic [3:0] wc);
    return ($countones({rc, wc}) != 1) || (r ? (rc == 0) : (wc == 0)) || wc[3];
  endfunction

  task automatic idle_bus();
    cs = '0; rd_ce = '0; wr_ce = '0; be = '0; wdata = '0; rnw = 1'b0;
  endtask

  // One full transfer starting at a falling edge; checks latency, flags, data.
  task automatic xfer(input logic r, input logic [3:0] rc, input logic [3:0] wc,
                      input logic [3:0] b, input logic [31:0] d,
                      input logic [3:0] ws, input int hold);
    bit f;
    int k;
    int idx;
    f = is_fault(r, rc, wc);
    idx = hot_idx(r ? rc : wc);
    @(negedge clk);
    cs = 1'b1; rnw = r; rd_ce = rc; wr_ce = wc; be = b; wdata = d; wait_states = ws;
    k = 0;
    #1;
    while (!(rd_ack || wr_ack) && k < 20) begin
      @(negedge clk); #1; k++;
    end
    chk(k == int'(ws), "R2 latency", 32'(k), 32'(ws));
    chk(rd_ack == r && wr_ack == !r, "R10 ack direction",
        {30'd0, rd_ack, wr_ack}, {30'd0, r, !r});
    if (f) begin
      chk(err == 1'b1, wc[3] ? "R6 ro write err" : "R7 fault err", 32'(err), 32'd1);
      if (r) chk(rdata == 32'd0, "R7 fault rdata", rdata, 32'd0);
    end else begin
      chk(err == 1'b0, "R8 no spurious err", 32'(err), 32'd0);
      if (r) chk(rdata == model[idx], "R5 read data", rdata, model[idx]);
      else   model[idx] = merge(model[idx], d, b);
    end
    for (int h = 0; h < hold; h++) begin
      @(negedge clk); #1;
      chk(!(rd_ack || wr_ack), "R3 no re-ack while held", 32'(rd_ack | wr_ack), 32'd0);
    end
    @(negedge clk);
    idle_bus();
    #1;
    chk(rdata == 32'd0 && !rd_ack, "R5 rdata zero after", rdata, 32'd0);
  endtask

  task automatic read_expect(input int i, input string tag);
    @(negedge clk);
    cs = 1'b1; rnw = 1'b1; rd_ce = 4'(1 << i); wait_states = '0;
    #1;
    chk(rd_ack && rdata == model[i], tag, rdata, model[i]);
    @(negedge clk);
    idle_bus();
  endtask

  initial begin
    void'($urandom(32'd1234));
    model[0] = '0; model[1] = '0; model[2] = '0; model[3] = RO_VAL;
    // R1: request during reset must not be acknowledged
    repeat (2) @(negedge clk);
    cs = 1'b1; rnw = 1'b1; rd_ce = 4'b0001;
    #1;
    chk(!(rd_ack || wr_ack), "R1 no ack in reset", 32'(rd_ack | wr_ack), 32'd0);
    @(negedge clk);
    idle_bus();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) read_expect(i, "R1 reset contents");

    // R2: each wait count on a clean write and read
    for (int w = 0; w < 5; w++) begin
      xfer(1'b0, 4'b0000, 4'b0001, 4'hF, 32'h1000_0000 + 32'(w), 4'(w), 0);
      xfer(1'b1, 4'b0001, 4'b0000, 4'h0, 32'h0, 4'(w), 0);
    end

    // R4: lane merge; 0011 touches lanes 2 and 3 (bits 15:0)
    xfer(1'b0, 4'b0000, 4'b0010, 4'hF, 32'hFFFF_FFFF, 4'd0, 0);
    xfer(1'b0, 4'b0000, 4'b0010, 4'b0011, 32'hAABB_CCDD, 4'd1, 0);
    model[1] = 32'hFFFF_CCDD;
    read_expect(1, "R4 lanes 2,3 only");
    xfer(1'b0, 4'b0000, 4'b0010, 4'b1000, 32'h1200_0000, 4'd0, 0);
    model[1] = 32'h12FF_CCDD;
    read_expect(1, "R4 lane 0 is bits 31:24");

    // R3: hold the request after the ack
    xfer(1'b1, 4'b0010, 4'b0000, 4'h0, 32'h0, 4'd2, 4);

    // R6: write to read-only register
    xfer(1'b0, 4'b0000, 4'b1000, 4'hF, 32'hDEAD_BEEF, 4'd1, 0);
    read_expect(3, "R6 ro unchanged");

    // R7: multi-hot and direction mismatch
    xfer(1'b0, 4'b0000, 4'b0101, 4'hF, 32'hCAFE_F00D, 4'd0, 0);
    xfer(1'b1, 4'b0011, 4'b0000, 4'h0, 32'h0, 4'd1, 0);
    xfer(1'b1, 4'b0000, 4'b0100, 4'h0, 32'h0, 4'd0, 0);
    read_expect(0, "R7 reg0 unchanged");
    read_expect(2, "R7 reg2 unchanged");

    // R9: abort before the wait count runs out
    @(negedge clk);
    cs = 1'b1; rnw = 1'b0; wr_ce = 4'b0001; be = 4'hF; wdata = 32'h0BAD_0BAD;
    wait_states = 4'd3;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(!wr_ack, "R9 no ack before count", 32'(wr_ack), 32'd0);
      @(negedge clk);
    end
    idle_bus();
    #1;
    chk(!wr_ack && !err, "R9 no ack after abort", 32'(wr_ack | err), 32'd0);
    read_expect(0, "R9 aborted write discarded");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic       r;
      logic [3:0] rc;
      logic [3:0] wc;
      logic [3:0] sel;
      r = 1'($urandom % 2);
      sel = 4'(1 << ($urandom % 4));
      rc = r ? sel : 4'b0000;
      wc = r ? 4'b0000 : sel;
      if ($urandom % 8 == 0) begin
        if ($urandom % 2 == 0) rc = rc | 4'(1 << ($urandom % 4));
        else                   wc = wc | 4'(1 << ($urandom % 4));
      end
      if (rc == 0 && wc == 0) wc = 4'b0001;
      xfer(r, rc, wc, 4'($urandom), $urandom, 4'($urandom % 4), int'($urandom % 3));
    end

    for (int i = 0; i < 4; i++) read_expect(i, "R5 final contents");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule